// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration register file of a multi-function I/O controller, reached through a two-byte window on a byte-wide host bus. Address bit 0 selects the port: when it is clear the access reaches the index port, and when it is set the access reaches the data port. A byte written to the index port selects one of three 8-bit configuration registers: slot 0 is function enable, slot 1 is function address, slot 2 is power/test. A read or write on the data port then reaches the selected register. All three register values are driven out continuously, so that downstream decoders can act on them.

After reset the index port does not echo the index at once. It first returns a two-byte identification sequence. A 5-bit strap input picks the reset contents of the three registers. Whenever a data write changes a stored value, the block raises a one-cycle pulse so that downstream logic can reconfigure.

Top module: `sio_cfg_port`

## Requirements
- R1: A write strobe with `bus_a0` = 0 stores `bus_wdata` as the 8-bit selected index. A write strobe with `bus_a0` = 1 writes the register in the selected slot. A data read with `bus_a0` = 1 returns that register.
- R2: A data write is stored only when the selected index is 0, 1 or 2. With any other index the write leaves all three register outputs unchanged.
- R3: A data read while the selected index is 3 or more returns 0x00.
- R4: After reset, the first index-port read returns 0x88 and the second returns 0x00. Every later index read returns the selected index.
- R5: A write to the index port ends the identification sequence at once. The next index read returns the index just written.
- R6: Synchronous reset selects index 0, restarts the identification sequence, clears `bus_rdata` and `cfg_changed`, and loads the registers from `strap` as the triple (enable, address, power). Strap 1 gives 0x4F/0x11/0x00. Strap 12 gives 0x0F/0x10/0x00. Strap 31 gives 0x00/0x10/0x02. Any other strap s gives (0x40 | s, 0x10 | (s & 3), 0x00).
- R7: `bus_rdata` is registered. It shows the value read in the cycle after the clock edge at which the read strobe was first seen high. It then holds that value until the next read.
- R8: An access takes effect only on the first clock edge at which its strobe is seen high. If a strobe stays high for more cycles, the access is not repeated and the identification sequence does not advance again. If both strobes rise together, only the write takes effect.
- R9: `cfg_changed` is high for exactly one cycle, the cycle after a data write that changes a stored register value. It stays low for writes that do not change any stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 5 | Reset-contents select, sampled while rst is high |
| bus_a0 | input | 1 | Port select: 0 index, 1 data |
| bus_wr | input | 1 | Write strobe, acts on its rising edge |
| bus_rd | input | 1 | Read strobe, acts on its rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| func_enable | output | 8 | Register slot 0 |
| func_address | output | 8 | Register slot 1 |
| power_test | output | 8 | Register slot 2 |
| cfg_changed | output | 1 | One-cycle pulse when a stored register changes |

## Verification
The identification sequence is hard to observe because it can be seen only once per reset, and any index write ends it early. The bench therefore resets before every strap value and reads the index port twice before touching anything else. It then checks the reset contents of all 32 strap entries, both on the register outputs and through data reads. Two further cases are also hard to reach: a strobe held high for several cycles, and a data write that repeats the stored value. The bench drives both on purpose, to show that neither one advances the sequence nor raises a spurious change pulse.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int CFG_DW      = 8;
  localparam int CFG_NREG    = 3;
  localparam int CFG_STRAP_W = 5;
  localparam logic [CFG_DW-1:0] ID_FIRST  = 8'h88;
  localparam logic [CFG_DW-1:0] ID_SECOND = 8'h00;

  typedef enum logic [1:0] {
    ID_AT_FIRST  = 2'd0,
    ID_AT_SECOND = 2'd1,
    ID_DONE      = 2'd2
  } id_step_t;

  // Reset contents of register slot k for a given strap value.
  function automatic logic [CFG_DW-1:0] strap_reg(input logic [CFG_STRAP_W-1:0] s,
                                                 input int k);
    logic [CFG_DW-1:0] ena, adr, pwr;
    case (s)
      5'd1:    begin ena = 8'h4F; adr = 8'h11; pwr = 8'h00; end
      5'd12:   begin ena = 8'h0F; adr = 8'h10; pwr = 8'h00; end
      5'd31:   begin ena = 8'h00; adr = 8'h10; pwr = 8'h02; end
      default: begin
        ena = 8'h40 | {3'b000, s};
        adr = 8'h10 | {6'b000000, s[1:0]};
        pwr = 8'h00;
      end
    endcase
    case (k)
      0:       return ena;
      1:       return adr;
      default: return pwr;
    endcase
  endfunction
endpackage

// File: rtl/sio_cfg_edge.sv
module sio_cfg_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end
  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/sio_cfg_index_port.sv
module sio_cfg_index_port
  import sio_cfg_pkg::*;
#(
  parameter int DW = CFG_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_fire,
  input  logic          wr_fire,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] sel_idx,
  output logic [DW-1:0] idx_rdata
);
  id_step_t step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= ID_AT_FIRST;
      sel_idx <= '0;
    end else if (wr_fire && !a0) begin
      sel_idx <= wdata;
      step_q  <= ID_DONE;
    end else if (rd_fire && !a0) begin
      case (step_q)
        ID_AT_FIRST:  step_q <= ID_AT_SECOND;
        ID_AT_SECOND: step_q <= ID_DONE;
        default:      step_q <= ID_DONE;
      endcase
    end
  end

  always_comb begin
    case (step_q)
      ID_AT_FIRST:  idx_rdata = ID_FIRST;
      ID_AT_SECOND: idx_rdata = ID_SECOND;
      default:      idx_rdata = sel_idx;
    endcase
  end

  // R5: an index write ends the ID sequence and captures the index
  p_idx_write_ends_id_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !a0) |=> (step_q == ID_DONE && sel_idx == $past(wdata)));

  // R8: no index-port read edge, no index write -> the step stays put
  p_step_needs_edge_r8: assert property (@(posedge clk) disable iff (rst)
    (!(rd_fire && !a0) && !(wr_fire && !a0)) |=> $stable(step_q));

  // R4: after the sequence has ended it never restarts without reset
  p_id_no_restart_r4: assert property (@(posedge clk) disable iff (rst)
    (step_q == ID_DONE) |=> (step_q == ID_DONE));
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter int DW      = CFG_DW,
  parameter int NREG    = CFG_NREG,
  parameter int STRAP_W = CFG_STRAP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               wr_fire,
  input  logic               a0,
  input  logic [DW-1:0]      sel_idx,
  input  logic [DW-1:0]      wdata,
  output logic [NREG*DW-1:0] regs_flat,
  output logic [DW-1:0]      data_rdata,
  output logic               changed
);
  logic [DW-1:0] regs_q [NREG];
  logic [NREG-1:0] diff;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic hit;
    assign hit  = wr_fire && a0 && (sel_idx == DW'(i));
    assign diff[i] = hit && (wdata != regs_q[i]);
    always_ff @(posedge clk) begin
      if (rst)      regs_q[i] <= strap_reg(strap, i);
      else if (hit) regs_q[i] <= wdata;
    end
    assign regs_flat[i*DW +: DW] = regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) changed <= 1'b0;
    else     changed <= |diff;
  end

  always_comb begin
    data_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (sel_idx == DW'(i)) data_rdata = regs_q[i];
  end

  // R2: a data write to an out-of-range slot leaves every register alone
  p_oob_write_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && a0 && (sel_idx >= DW'(NREG))) |=> $stable(regs_flat));

  // R9: the pulse only ever follows a data-port write edge
  p_pulse_after_write_r9: assert property (@(posedge clk) disable iff (rst)
    changed |-> $past(wr_fire && a0));

  // R9: the pulse lasts one cycle
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
    changed |=> !changed);
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int DW      = CFG_DW,
  parameter int NREG    = CFG_NREG,
  parameter int STRAP_W = CFG_STRAP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  input  logic               bus_a0,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [DW-1:0]      func_enable,
  output logic [DW-1:0]      func_address,
  output logic [DW-1:0]      power_test,
  output logic               cfg_changed
);
  logic wr_rise, rd_rise, rd_fire;
  logic [DW-1:0] sel_idx, idx_rdata, data_rdata;
  logic [NREG*DW-1:0] regs_flat;

  sio_cfg_edge u_wr_edge (.clk(clk), .rst(rst), .lvl(bus_wr), .rise(wr_rise));
  sio_cfg_edge u_rd_edge (.clk(clk), .rst(rst), .lvl(bus_rd), .rise(rd_rise));

  // a write rising together with a read wins
  assign rd_fire = rd_rise & ~wr_rise;

  sio_cfg_index_port #(.DW(DW)) u_index (
    .clk(clk), .rst(rst), .rd_fire(rd_fire), .wr_fire(wr_rise),
    .a0(bus_a0), .wdata(bus_wdata), .sel_idx(sel_idx), .idx_rdata(idx_rdata)
  );

  sio_cfg_regfile #(.DW(DW), .NREG(NREG), .STRAP_W(STRAP_W)) u_regs (
    .clk(clk), .rst(rst), .strap(strap), .wr_fire(wr_rise), .a0(bus_a0),
    .sel_idx(sel_idx), .wdata(bus_wdata), .regs_flat(regs_flat),
    .data_rdata(data_rdata), .changed(cfg_changed)
  );

  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (rd_fire) bus_rdata <= bus_a0 ? data_rdata : idx_rdata;
  end

  assign func_enable  = regs_flat[0*DW +: DW];
  assign func_address = regs_flat[1*DW +: DW];
  assign power_test   = regs_flat[2*DW +: DW];

  // R7: read data holds between reads
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(bus_rdata));

  // R3: a data read of an unused slot yields zero
  p_oob_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && bus_a0 && (sel_idx >= DW'(NREG))) |=> (bus_rdata == '0));
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] strap = '0;
  logic bus_a0 = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, func_enable, func_address, power_test;
  logic cfg_changed;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [7:0] model [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_port dut_i (
    .clk(clk), .rst(rst), .strap(strap), .bus_a0(bus_a0), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .func_enable(func_enable), .func_address(func_address),
    .power_test(power_test), .cfg_changed(cfg_changed)
  );

  // reset table as stated in R6
  function automatic logic [7:0] exp_reset(input int s, input int k);
    if (s == 1)  return (k == 0) ? 8'h4F : (k == 1) ? 8'h11 : 8'h00;
    if (s == 12) return (k == 0) ? 8'h0F : (k == 1) ? 8'h10 : 8'h00;
    if (s == 31) return (k == 0) ? 8'h00 : (k == 1) ? 8'h10 : 8'h02;
    if (k == 0) return 8'(64 + s);
    if (k == 1) return 8'(16 + (s % 4));
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset(input int s);
    @(negedge clk);
    rst = 1'b1; strap = 5'(s); bus_rd = 0; bus_wr = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) model[k] = exp_reset(s, k);
  endtask

  task automatic wr_acc(input logic a, input logic [7:0] d, output logic chg);
    @(negedge clk); bus_a0 = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; chg = cfg_changed;
  endtask

  task automatic rd_acc(input logic a, output logic [7:0] v);
    @(negedge clk); bus_a0 = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic check_outs(input string req);
    check(req, func_enable, model[0]);
    check(req, func_address, model[1]);
    check(req, power_test, model[2]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic chg;
    logic [7:0] vals [4] = '{8'h00, 8'hA5, 8'h5A, 8'hFF};

    // R6 + R4 + R1: every strap, reset contents and ID sequence
    for (int s = 0; s < 32; s++) begin
      do_reset(s);
      check("R6 rdata", bus_rdata, 8'h00);
      check("R6 changed", {7'b0, cfg_changed}, 8'h00);
      check_outs("R6 outs");
      rd_acc(1'b0, v); check("R4 id0", v, 8'h88);
      rd_acc(1'b0, v); check("R4 id1", v, 8'h00);
      rd_acc(1'b0, v); check("R4 R6 index0", v, 8'h00);
      for (int k = 0; k < 3; k++) begin
        wr_acc(1'b0, 8'(k), chg);
        rd_acc(1'b1, v); check("R1 R6 data read", v, exp_reset(s, k));
      end
    end

    // R5: an index write cuts the ID sequence short
    do_reset(1);
    wr_acc(1'b0, 8'h02, chg);
    rd_acc(1'b0, v); check("R5 index echo", v, 8'h02);
    do_reset(1);
    rd_acc(1'b0, v); check("R5 id0", v, 8'h88);
    wr_acc(1'b0, 8'h07, chg);
    rd_acc(1'b0, v); check("R5 echo mid-seq", v, 8'h07);

    // R1 R2 R3 R9: write sweep over indices and values
    do_reset(12);
    for (int idx = 0; idx < 8; idx++) begin
      for (int j = 0; j < 4; j++) begin
        wr_acc(1'b0, 8'(idx), chg);
        wr_acc(1'b1, vals[j], chg);
        check("R9 pulse", {7'b0, chg},
              {7'b0, (idx < 3) && (vals[j] != model[idx < 3 ? idx : 0])});
        if (idx < 3) model[idx] = vals[j];
        @(negedge clk);
        check("R9 single", {7'b0, cfg_changed}, 8'h00);
        check_outs("R2 outs");
        rd_acc(1'b1, v);
        check(idx < 3 ? "R1 readback" : "R3 oob read", v, idx < 3 ? vals[j] : 8'h00);
      end
    end

    // R9: rewrite of same value gives no pulse
    wr_acc(1'b0, 8'h01, chg);
    wr_acc(1'b1, model[1], chg);
    check("R9 no pulse same", {7'b0, chg}, 8'h00);

    // R8: held read strobe advances once
    do_reset(31);
    @(negedge clk); bus_a0 = 1'b0; bus_rd = 1'b1;
    repeat (4) @(negedge clk);
    bus_rd = 1'b0;
    check("R8 held read", bus_rdata, 8'h88);
    rd_acc(1'b0, v); check("R8 next id", v, 8'h00);
    // R8: held write stores once, pulse once
    wr_acc(1'b0, 8'h00, chg);
    @(negedge clk); bus_a0 = 1'b1; bus_wdata = 8'h3C; bus_wr = 1'b1;
    @(negedge clk); check("R8 R9 held write pulse", {7'b0, cfg_changed}, 8'h01);
    @(negedge clk); check("R8 held write no repeat", {7'b0, cfg_changed}, 8'h00);
    bus_wr = 1'b0;
    check("R8 stored", func_enable, 8'h3C);
    // R8: simultaneous strobes, write wins
    @(negedge clk); @(negedge clk);
    bus_a0 = 1'b0; bus_wdata = 8'h01; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b0;
    check("R8 write wins rdata", bus_rdata, 8'h00);
    rd_acc(1'b0, v); check("R8 write wins index", v, 8'h01);

    // R7: read data holds during idle cycles
    repeat (5) @(negedge clk);
    check("R7 hold", bus_rdata, 8'h01);
    rd_acc(1'b1, v); check("R7 data after read", v, 8'h10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule